// File: doc/BRIEF.md
# Watch Prescaler Interval Timer

This block is a free-running down-counter clocked from one of two slow oscillators. It raises an interval interrupt each time a chosen counter bit falls from 1 to 0. The slow oscillators sit outside the block. Each one reaches the block as three signals: a one-cycle tick strobe in the system clock domain that marks each oscillator edge, an enable, and a "stabilized" status. The counter advances once for every two ticks of the selected source. It starts from all ones and wraps from zero back to all ones.

Software reaches the block through one control register. Through it, software requests a clear, picks one of four interval taps, reads and acknowledges the interrupt flag, and masks the interrupt. The counter is also cleared by the hardware itself in three cases: when stop mode is entered while the device runs from the slow clock, when the selected source changes, and when the active oscillator is switched off. A one-cycle `wdt_clr` pulse goes out with every clear, so that a watchdog counting from this prescaler can restart in step with it. The clock-source selection is only ever updated on a cycle in which the counter is being forced to all ones. As a result, a source change can never corrupt a count that is in progress.

Top module: `watch_prescaler`

## Requirements
- R1: After reset, `count` is all ones, `rd_data` is 0, `irq` is 0 and `wdt_clr` is 0. The counter stays at all ones while no clock source is available.
- R2: With a source selected, `count` decreases by exactly one for every two cycles in which that source's tick strobe is high. The first decrement comes on the second tick after a clear.
- R3: From zero, the next decrement gives all ones, and counting carries on.
- R4: With interval select s (0 to 3), the flag sets when counter bit TAP_LO+TAP_STEP*s falls from 1 to 0. Measured from a clear, this first happens after 2^k decrements, where k is that bit index, and then every 2^(k+1) decrements.
- R5: Register layout. Bit 0 is the clear command: writing 1 clears, and it always reads 0. Bits 2:1 hold the interval select. Bit 3 is the flag: writing 0 clears it and writing 1 has no effect. Bit 4 is the interrupt enable. Bits 7:5 read 0. `irq` is the flag ANDed with the enable.
- R6: Writing 1 to the clear bit returns the counter to all ones and restarts the divide-by-two phase. On the following cycle, `wdt_clr` is high for exactly one cycle.
- R7: In high-speed mode (`lowspeed_mode`=0), the crystal source is used if it is both enabled and stabilized. Failing that, the internal RC source is used if it is enabled and stabilized. Otherwise there is no source. In low-speed mode only the crystal source may be used.
- R8: Any change of the selected source clears the counter and pulses `wdt_clr`. Dropping the active oscillator's enable counts as such a change.
- R9: When `stop_mode` rises while `lowspeed_mode` is 1, the counter is cleared and `wdt_clr` pulses. The counter then holds at all ones until stop mode ends.
- R10: The flag never sets while `stop_mode` and `lowspeed_mode` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| xtal_en | input | 1 | Crystal slow oscillator enable |
| xtal_ready | input | 1 | Crystal oscillator stabilization done |
| xtal_tick | input | 1 | One-cycle strobe per crystal oscillator edge |
| rc_en | input | 1 | Internal RC slow oscillator enable |
| rc_ready | input | 1 | RC oscillator stabilization done |
| rc_tick | input | 1 | One-cycle strobe per RC oscillator edge |
| lowspeed_mode | input | 1 | Device is running from the slow clock |
| stop_mode | input | 1 | Device is in stop mode |
| count | output | CNT_W (16) | Current prescaler value |
| irq | output | 1 | Interval interrupt request |
| wdt_clr | output | 1 | One-cycle clear pulse for a dependent watchdog |

## Verification
The hardest case to reach is a source handover while counting is under way. It needs both oscillators enabled and stabilized at once, with tick strobes arriving on each, followed by the loss of the preferred one. The bench first proves that RC ticks are ignored while the crystal is preferred. It then drops the crystal enable in high-speed mode and checks that the counter restarts from all ones on RC ticks. A second hard case is stop mode under the slow clock. There, the bench ticks the crystal through more than a full interval and confirms that the flag stays low. Interval timing is swept over all four taps, with tick counts checked against powers of two.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int REG_W    = 8;
   localparam int CLR_BIT  = 0;
   localparam int SEL_LSB  = 1;
   localparam int SEL_W    = 2;
   localparam int FLAG_BIT = 3;
   localparam int IE_BIT   = 4;
   localparam int NUM_TAPS = 1 << SEL_W;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_XTAL = 2'd1,
      SRC_RC   = 2'd2
   } src_e;
endpackage

// File: rtl/wp_clk_sel.sv
module wp_clk_sel
   import wp_pkg::*;
#(
   parameter bit HAS_RC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xtal_en,
   input  logic xtal_ready,
   input  logic xtal_tick,
   input  logic rc_en,
   input  logic rc_ready,
   input  logic rc_tick,
   input  logic lowspeed_mode,
   output logic src_chg,
   output logic src_none,
   output logic tick_sel
);
   logic xt_ok;
   logic rc_ok;
   src_e want;
   src_e cur_q;

   assign xt_ok = xtal_en & xtal_ready;

   generate
      if (HAS_RC) begin : g_rc
         assign rc_ok = rc_en & rc_ready & ~lowspeed_mode;
      end else begin : g_no_rc
         logic unused_rc;
         assign unused_rc = rc_en ^ rc_ready ^ rc_tick;
         assign rc_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (xt_ok)      want = SRC_XTAL;
      else if (rc_ok) want = SRC_RC;
      else            want = SRC_NONE;
   end

   // the selection register only moves while src_chg forces a clear
   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= SRC_NONE;
      else        cur_q <= want;
   end

   assign src_chg  = (want != cur_q);
   assign src_none = (cur_q == SRC_NONE);

   always_comb begin
      unique case (cur_q)
         SRC_XTAL: tick_sel = xtal_tick;
         SRC_RC:   tick_sel = rc_tick;
         default:  tick_sel = 1'b0;
      endcase
   end
endmodule

// File: rtl/wp_counter.sv
module wp_counter
   import wp_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int TAP_LO   = 9,
   parameter int TAP_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             hold,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt,
   output logic             tap_fall
);
   localparam int TOP_TAP = TAP_LO + (NUM_TAPS - 1) * TAP_STEP;

   generate
      if (TOP_TAP >= CNT_W || TAP_STEP < 1 || TAP_LO < 0) begin : g_bad_cfg
         $error("wp_counter: tap layout does not fit the counter width");
      end
   endgenerate

   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             dec;
   logic [NUM_TAPS-1:0] fall_v;

   assign cnt_nx = cnt_q - 1'b1;
   assign dec    = tick & phase_q & ~clr & ~hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         phase_q <= 1'b0;
      end else if (clr || hold) begin
         cnt_q   <= '1;
         phase_q <= 1'b0;
      end else if (tick) begin
         phase_q <= ~phase_q;
         if (phase_q) cnt_q <= cnt_nx;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
         localparam int BIT = TAP_LO + gi * TAP_STEP;
         assign fall_v[gi] = dec & cnt_q[BIT] & ~cnt_nx[BIT];
      end
   endgenerate

   assign tap_fall = fall_v[sel];
   assign cnt      = cnt_q;
endmodule

// File: rtl/wp_regs.sv
module wp_regs
   import wp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             tap_fall,
   input  logic             suppress,
   output logic             sw_clr,
   output logic [SEL_W-1:0] sel,
   output logic [REG_W-1:0] rd_data,
   output logic             irq
);
   logic             flag_q;
   logic             ie_q;
   logic [SEL_W-1:0] sel_q;
   logic             unused_hi;

   assign unused_hi = ^wr_data[REG_W-1:IE_BIT+1];
   assign sw_clr    = wr_en & wr_data[CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
         sel_q  <= '0;
      end else begin
         if (wr_en) begin
            ie_q  <= wr_data[IE_BIT];
            sel_q <= wr_data[SEL_LSB +: SEL_W];
         end
         if (tap_fall && !suppress)
            flag_q <= 1'b1;
         else if (wr_en && !wr_data[FLAG_BIT])
            flag_q <= 1'b0;
      end
   end

   assign sel = sel_q;
   assign irq = flag_q & ie_q;

   always_comb begin
      rd_data                     = '0;
      rd_data[SEL_LSB +: SEL_W]   = sel_q;
      rd_data[FLAG_BIT]           = flag_q;
      rd_data[IE_BIT]             = ie_q;
   end
endmodule

// File: rtl/watch_prescaler.sv
module watch_prescaler
   import wp_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int TAP_LO   = 9,
   parameter int TAP_STEP = 2,
   parameter bit HAS_RC   = 1'b1,
   parameter bit WDT_LINK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic             xtal_en,
   input  logic             xtal_ready,
   input  logic             xtal_tick,
   input  logic             rc_en,
   input  logic             rc_ready,
   input  logic             rc_tick,
   input  logic             lowspeed_mode,
   input  logic             stop_mode,
   output logic [CNT_W-1:0] count,
   output logic             irq,
   output logic             wdt_clr
);
   generate
      if (REG_W != 8 || CNT_W < 4) begin : g_bad_top
         $error("watch_prescaler: unsupported register or counter width");
      end
   endgenerate

   logic             src_chg;
   logic             src_none;
   logic             tick_sel;
   logic             sw_clr;
   logic             tap_fall;
   logic [SEL_W-1:0] sel;
   logic             stop_q;
   logic             slow_stop;
   logic             stop_entry;
   logic             clr_evt;
   logic             hold;

   assign slow_stop  = stop_mode & lowspeed_mode;
   assign stop_entry = slow_stop & ~stop_q;
   assign clr_evt    = sw_clr | stop_entry | src_chg;
   assign hold       = src_none | slow_stop;

   always_ff @(posedge clk) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= slow_stop;
   end

   wp_clk_sel #(.HAS_RC(HAS_RC)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .xtal_en(xtal_en), .xtal_ready(xtal_ready), .xtal_tick(xtal_tick),
      .rc_en(rc_en), .rc_ready(rc_ready), .rc_tick(rc_tick),
      .lowspeed_mode(lowspeed_mode),
      .src_chg(src_chg), .src_none(src_none), .tick_sel(tick_sel)
   );

   wp_counter #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .hold(hold),
      .tick(tick_sel), .sel(sel), .cnt(count), .tap_fall(tap_fall)
   );

   wp_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tap_fall(tap_fall), .suppress(slow_stop),
      .sw_clr(sw_clr), .sel(sel), .rd_data(rd_data), .irq(irq)
   );

   generate
      if (WDT_LINK) begin : g_wdt
         logic wdt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) wdt_q <= 1'b0;
            else        wdt_q <= clr_evt;
         end
         assign wdt_clr = wdt_q;
      end else begin : g_no_wdt
         assign wdt_clr = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
   parameter int CNT_W    = 16,
   parameter bit WDT_LINK = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_wr_clr,
   input logic             flag,
   input logic             slow_stop,
   input logic [CNT_W-1:0] count,
   input logic             wdt_clr
);
   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == $past(count) - 1'b1 || count == '1));

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count) == '0 && count != '0) |-> (count == '1));

   // R6
   swclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_clr |=> (count == '1 && (wdt_clr || !WDT_LINK)));

   // R8
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |-> (count == '1));

   // R9
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_stop |=> (count == '1));

   // R10
   stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_stop |=> !$rose(flag));
endmodule

bind watch_prescaler wp_checker #(.CNT_W(CNT_W), .WDT_LINK(WDT_LINK)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .sw_wr_clr(wr_en & wr_data[0]),
   .flag(rd_data[3]),
   .slow_stop(stop_mode & lowspeed_mode),
   .count(count), .wdt_clr(wdt_clr)
);

// File: tb/sim_watch_prescaler.sv
`timescale 1ns/1ps
module sim_watch_prescaler;
   localparam int CW = 8;
   localparam int TL = 1;
   localparam int TS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic          xtal_en = 1'b0, xtal_ready = 1'b0, xtal_tick = 1'b0;
   logic          rc_en = 1'b0, rc_ready = 1'b0, rc_tick = 1'b0;
   logic          lowspeed_mode = 1'b0, stop_mode = 1'b0;
   logic [CW-1:0] count;
   logic          irq, wdt_clr;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   watch_prescaler #(.CNT_W(CW), .TAP_LO(TL), .TAP_STEP(TS)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .xtal_en(xtal_en), .xtal_ready(xtal_ready), .xtal_tick(xtal_tick),
      .rc_en(rc_en), .rc_ready(rc_ready), .rc_tick(rc_tick),
      .lowspeed_mode(lowspeed_mode), .stop_mode(stop_mode),
      .count(count), .irq(irq), .wdt_clr(wdt_clr)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_err = n_err + 1;
         n_chk = n_chk + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_err = n_err + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // fields: bit0 clear, bits2:1 select, bit3 flag (0 clears), bit4 enable
   task automatic wreg(input bit clr, input int sel, input bit keep_flag, input bit ie);
      wr_en   = 1'b1;
      wr_data = {3'b000, ie, keep_flag, sel[1:0], clr};
      step();
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   initial begin
      int k;
      int t;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 count", int'(count), 255);
      chk("R1 rd_data", int'(rd_data), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 wdt_clr", int'(wdt_clr), 0);
      // R1 no source: ticks ignored
      xtal_tick = 1'b1; rc_tick = 1'b1;
      repeat (10) step();
      xtal_tick = 1'b0; rc_tick = 1'b0;
      chk("R1 halted", int'(count), 255);

      // R8 source appears
      xtal_en = 1'b1; xtal_ready = 1'b1;
      step();
      chk("R8 wdt pulse on select", int'(wdt_clr), 1);
      step();
      chk("R8 pulse one cycle", int'(wdt_clr), 0);

      // R6 software clear, R5 clear bit reads 0
      wreg(1'b1, 0, 1'b0, 1'b0);
      chk("R6 wdt_clr", int'(wdt_clr), 1);
      chk("R5 clear reads 0", int'(rd_data[0]), 0);
      // R2 R3 exhaustive walk over all counter values
      xtal_tick = 1'b1;
      for (int i = 1; i <= 512; i++) begin
         step();
         chk("R2 R3 count walk", int'(count), (255 - i / 2) & 255);
      end
      xtal_tick = 1'b0;

      // R4 sweep of all taps
      for (int s = 0; s < 4; s++) begin
         k = TL + TS * s;
         wreg(1'b1, s, 1'b0, 1'b1);
         chk("R5 select readback", int'(rd_data[2:1]), s);
         xtal_tick = 1'b1;
         t = 0;
         while (!rd_data[3] && t < 2000) begin step(); t++; end
         xtal_tick = 1'b0;
         chk("R4 first interval", t, 1 << (k + 1));
         chk("R5 irq with enable", int'(irq), 1);
         wreg(1'b0, s, 1'b0, 1'b1);
         chk("R5 flag write 0", int'(rd_data[3]), 0);
         xtal_tick = 1'b1;
         t = 0;
         while (!rd_data[3] && t < 2000) begin step(); t++; end
         xtal_tick = 1'b0;
         chk("R4 repeat interval", t, 1 << (k + 2));
      end

      // R5 irq masking and write-1 to flag
      wreg(1'b0, 0, 1'b1, 1'b0);
      chk("R5 flag kept", int'(rd_data[3]), 1);
      chk("R5 irq masked", int'(irq), 0);
      wreg(1'b0, 0, 1'b0, 1'b0);
      wreg(1'b0, 0, 1'b1, 1'b1);
      chk("R5 write 1 no effect", int'(rd_data[3]), 0);
      chk("R5 upper bits", int'(rd_data[7:5]), 0);

      // R7 priority: both sources ready, crystal wins
      rc_en = 1'b1; rc_ready = 1'b1;
      step();
      chk("R7 no switch", int'(wdt_clr), 0);
      wreg(1'b1, 0, 1'b0, 1'b0);
      rc_tick = 1'b1; repeat (8) step(); rc_tick = 1'b0;
      chk("R7 rc ignored", int'(count), 255);
      xtal_tick = 1'b1; repeat (8) step(); xtal_tick = 1'b0;
      chk("R7 crystal counts", int'(count), 251);
      // R8 active enable dropped in high-speed mode
      xtal_en = 1'b0;
      step();
      chk("R8 wdt on drop", int'(wdt_clr), 1);
      chk("R8 count cleared", int'(count), 255);
      rc_tick = 1'b1; repeat (8) step(); rc_tick = 1'b0;
      chk("R7 rc fallback", int'(count), 251);

      // R7 low-speed mode: rc not allowed
      lowspeed_mode = 1'b1;
      step();
      chk("R8 wdt on loss", int'(wdt_clr), 1);
      rc_tick = 1'b1; repeat (8) step(); rc_tick = 1'b0;
      chk("R7 rc blocked in low-speed", int'(count), 255);

      // R9 R10 stop entry under low-speed clock
      xtal_en = 1'b1;
      step();
      wreg(1'b0, 0, 1'b0, 1'b1);
      xtal_tick = 1'b1; repeat (2) step(); xtal_tick = 1'b0;
      chk("R9 counting before stop", int'(count), 254);
      stop_mode = 1'b1;
      step();
      chk("R9 wdt on stop", int'(wdt_clr), 1);
      chk("R9 cleared", int'(count), 255);
      xtal_tick = 1'b1; repeat (20) step(); xtal_tick = 1'b0;
      chk("R9 held", int'(count), 255);
      chk("R10 no flag in stop", int'(rd_data[3]), 0);
      stop_mode = 1'b0;
      step();
      xtal_tick = 1'b1; repeat (4) step(); xtal_tick = 1'b0;
      chk("R4 resumes after stop", int'(rd_data[3]), 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule